// File: doc/BRIEF.md
# Banked Per-Core Countdown Timer Wrapper

This block holds one private countdown timer for each core of a cluster, with a core count set by parameter between one and a fixed maximum. All timers share one register space cut into 32-byte windows. Window 0 is an alias: an access there reaches the timer of the core named on the core-ID input that comes with the access, so every core can use one address for its own timer. Window i+1 reaches the timer of core i directly, for code that manages another core's timer.

The wrapper decodes the address and steers the access to one timer. It returns read data one cycle after the request. It drops accesses that are not full aligned words, accesses to windows past the last built core, and alias accesses from core IDs that have no timer. An alias access from an unknown core also raises a one-cycle error pulse. Each timer drives its own interrupt line, with core 0 on bit 0. A core count outside one to the maximum stops elaboration with an error.

Top module: `banked_core_timer`

## Requirements
- R1: Window w starts at byte address 32*w. Inside a window, the word offsets are: 0x00 load, 0x04 count, 0x08 control, 0x0C status. Offsets 0x10 to 0x1C read as zero and ignore writes. A write to load also copies the value into count.
- R2: Window i+1, for i below NUM_CORES, reads and writes the timer of core i.
- R3: Window 0 reads and writes the timer of the core given on req_core_id when that ID is below NUM_CORES.
- R4: An access to window 0 with req_core_id at or above NUM_CORES changes no timer and returns zero if it is a read. alias_err is high for exactly the cycle after that access.
- R5: An access to a window above NUM_CORES reads as zero, changes no timer and does not raise alias_err.
- R6: Only accesses with req_size = 2 (word) and req_addr[1:0] = 0 take effect. Any other access changes nothing and reads as zero.
- R7: The read data appears on rsp_rdata in the cycle after the read request and holds until the next read request.
- R8: The control register has bit 0 = run, bit 1 = reload, bit 2 = interrupt enable and bits 15:8 = prescale. While running with prescale 0, the count drops by one every cycle. A step from 1 to 0 sets status bit 0. core_irq[i] is status bit 0 of core i ANDed with that core's interrupt enable.
- R9: Writing 1 to status bit 0 clears it. Writing 0 there leaves it unchanged.
- R10: Reset clears every timer's load, count, control and status, drives every core_irq bit low, drives alias_err low and drives rsp_rdata to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_core_id | input | CORE_ID_W | ID of the requesting core |
| req_addr | input | ADDR_W | Byte address within the timer space |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| alias_err | output | 1 | Pulse after an alias access from an unknown core |
| core_irq | output | NUM_CORES | Timer interrupt per core, core 0 at bit 0 |

## Verification
The bench uses three cores out of a maximum of four. It sweeps every window and every core ID, so it can catch a design that sends alias accesses to the wrong core or off by one window. It also catches one that lets ID 3 write a timer through the alias window, or one that aliases window 4 onto a real core. Partial and misaligned accesses are aimed at live registers, so a design that ignored size or alignment would corrupt a load value. The interrupt test counts the exact cycle of expiry and checks the other cores' lines, which exposes an off-by-one countdown or a crossed interrupt bit. It also checks that write-one-to-clear drops the line.

// File: rtl/bct_pkg.sv
package bct_pkg;
  localparam int WORD_W    = 32;
  localparam int WIN_BYTES = 32;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef logic [2:0] reg_idx_t;
  localparam reg_idx_t REG_LOAD   = 3'd0;
  localparam reg_idx_t REG_COUNT  = 3'd1;
  localparam reg_idx_t REG_CTRL   = 3'd2;
  localparam reg_idx_t REG_STATUS = 3'd3;

  // Strobes from the decode control to the timer datapath
  typedef struct packed {
    logic     wrHit;   // write that reaches a real timer
    logic     rdReq;   // any read request
    logic     rdHit;   // read that reaches a real timer
    reg_idx_t regIdx;  // word offset inside the window
  } bct_strobe_t;
endpackage

// File: rtl/bct_timer.sv
module bct_timer
  import bct_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  reg_idx_t          regIdx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdVal,
  output logic              irq
);
  logic [WORD_W-1:0] loadR;
  logic [WORD_W-1:0] countR;
  logic              runR;
  logic              reloadR;
  logic              irqEnR;
  logic [PRE_W-1:0]  preR;
  logic [PRE_W-1:0]  preCnt;
  logic              statusR;

  logic tick;
  logic cntWrite;
  logic expire;
  logic clrStatus;

  assign tick      = runR && (preCnt == '0);
  assign cntWrite  = wrEn && ((regIdx == REG_LOAD) || (regIdx == REG_COUNT));
  assign expire    = tick && (countR == WORD_W'(1)) && !cntWrite;
  assign clrStatus = wrEn && (regIdx == REG_STATUS) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loadR   <= '0;
      countR  <= '0;
      runR    <= 1'b0;
      reloadR <= 1'b0;
      irqEnR  <= 1'b0;
      preR    <= '0;
      preCnt  <= '0;
      statusR <= 1'b0;
    end else begin
      if (wrEn && regIdx == REG_LOAD) begin
        loadR  <= wdata;
        countR <= wdata;
      end else if (wrEn && regIdx == REG_COUNT) begin
        countR <= wdata;
      end else if (tick) begin
        if (countR != '0) countR <= countR - WORD_W'(1);
        else if (reloadR) countR <= loadR;
      end

      if (wrEn && regIdx == REG_CTRL) begin
        runR    <= wdata[0];
        reloadR <= wdata[1];
        irqEnR  <= wdata[2];
        preR    <= wdata[8 +: PRE_W];
        preCnt  <= wdata[8 +: PRE_W];
      end else if (runR) begin
        preCnt <= (preCnt == '0) ? preR : preCnt - PRE_W'(1);
      end

      statusR <= (statusR && !clrStatus) || expire;
    end
  end

  always_comb begin
    unique case (regIdx)
      REG_LOAD:   rdVal = loadR;
      REG_COUNT:  rdVal = countR;
      REG_CTRL:   rdVal = (WORD_W'(preR) << 8) |
                          {{(WORD_W-3){1'b0}}, irqEnR, reloadR, runR};
      REG_STATUS: rdVal = {{(WORD_W-1){1'b0}}, statusR};
      default:    rdVal = '0;
    endcase
  end

  assign irq = statusR && irqEnR;

  // R8: status only rises after a running timer stepped from one to zero
  p_status_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusR) |-> $past(runR && countR == WORD_W'(1)));

  // R9: a write-one to status with no expiry leaves it clear
  p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clrStatus && !expire) |=> !statusR);
endmodule

// File: rtl/bct_ctrl.sv
module bct_ctrl
  import bct_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_ID_W = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [CORE_ID_W-1:0] req_core_id,
  input  logic [ADDR_W-1:0]    req_addr,
  output bct_strobe_t          stb,
  output logic [CORE_ID_W-1:0] tgtCore,
  output logic                 aliasErr
);
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam int WIN_W = ADDR_W - OFF_W;
  localparam logic [WIN_W-1:0]   LAST_WIN   = WIN_W'(NUM_CORES);
  localparam logic [CORE_ID_W:0] CORE_LIMIT = (CORE_ID_W+1)'(NUM_CORES);

  logic [WIN_W-1:0] winIdx;
  logic isAlias;
  logic idOk;
  logic winOk;
  logic wordOk;
  logic hit;

  assign winIdx  = req_addr[ADDR_W-1:OFF_W];
  assign isAlias = (winIdx == '0);
  assign idOk    = ({1'b0, req_core_id} < CORE_LIMIT);
  assign winOk   = (winIdx <= LAST_WIN);
  assign wordOk  = (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00);
  assign hit     = req_valid && wordOk && (isAlias ? idOk : winOk);
  assign tgtCore = isAlias ? req_core_id : CORE_ID_W'(winIdx - WIN_W'(1));

  always_comb begin
    stb.wrHit  = hit && req_write;
    stb.rdReq  = req_valid && !req_write;
    stb.rdHit  = hit && !req_write;
    stb.regIdx = req_addr[4:2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) aliasErr <= 1'b0;
    else        aliasErr <= req_valid && isAlias && !idOk;
  end

  // R4: an alias access from an unknown core never reaches a timer
  p_bad_alias_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && isAlias && !idOk) |-> !(stb.wrHit || stb.rdHit));

  // R5: windows above the last core reach nothing and raise no error
  p_high_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !winOk) |-> (!(stb.wrHit || stb.rdHit)) ##1 !aliasErr);

  // R6: non-word accesses produce no strobe
  p_partial_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SIZE_WORD) |-> !(stb.wrHit || stb.rdHit));
endmodule

// File: rtl/bct_datapath.sv
module bct_datapath
  import bct_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_ID_W = 2,
  parameter int PRE_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bct_strobe_t          stb,
  input  logic [CORE_ID_W-1:0] tgtCore,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdData,
  output logic [NUM_CORES-1:0] irq
);
  logic [WORD_W-1:0] rdVal [NUM_CORES];
  logic [WORD_W-1:0] rdSel;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic wrSel;
    assign wrSel = stb.wrHit && (tgtCore == CORE_ID_W'(c));
    bct_timer #(.PRE_W(PRE_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrEn   (wrSel),
      .regIdx (stb.regIdx),
      .wdata  (wdata),
      .rdVal  (rdVal[c]),
      .irq    (irq[c])
    );
  end

  always_comb begin
    rdSel = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (tgtCore == CORE_ID_W'(c)) rdSel = rdVal[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdData <= '0;
    else if (stb.rdReq) rdData <= stb.rdHit ? rdSel : '0;
  end

  // R7: a read that hits no timer returns zero in the following cycle
  p_miss_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdReq && !stb.rdHit) |=> (rdData == '0));

  // R7: read data holds between read requests
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.rdReq) |=> $stable(rdData));
endmodule

// File: rtl/banked_core_timer.sv
module banked_core_timer
  import bct_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int MAX_CORES = 4,
  parameter int PRE_W     = 8,
  localparam int CORE_ID_W = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1,
  localparam int ADDR_W    = $clog2((MAX_CORES + 1) * WIN_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [CORE_ID_W-1:0] req_core_id,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic [WORD_W-1:0]    rsp_rdata,
  output logic                 alias_err,
  output logic [NUM_CORES-1:0] core_irq
);
  if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cfg
    $error("banked_core_timer: NUM_CORES must lie in 1..MAX_CORES");
  end

  bct_strobe_t          stb;
  logic [CORE_ID_W-1:0] tgtCore;

  bct_ctrl #(
    .NUM_CORES (NUM_CORES),
    .CORE_ID_W (CORE_ID_W),
    .ADDR_W    (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_core_id (req_core_id),
    .req_addr    (req_addr),
    .stb         (stb),
    .tgtCore     (tgtCore),
    .aliasErr    (alias_err)
  );

  bct_datapath #(
    .NUM_CORES (NUM_CORES),
    .CORE_ID_W (CORE_ID_W),
    .PRE_W     (PRE_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .tgtCore (tgtCore),
    .wdata   (req_wdata),
    .rdData  (rsp_rdata),
    .irq     (core_irq)
  );
endmodule

// File: tb/banked_core_timer_bench.sv
module banked_core_timer_bench;
  localparam int NC = 3;
  localparam int MC = 4;
  localparam int IDW = 2;
  localparam int AW = 8;
  localparam time CLK_HALF = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [1:0] req_size = 2'd2;
  logic [IDW-1:0] req_core_id = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic alias_err;
  logic [NC-1:0] core_irq;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] expLoad [NC];
  logic [31:0] rd;
  logic errSeen;

  always #CLK_HALF clk = ~clk;

  banked_core_timer #(.NUM_CORES(NC), .MAX_CORES(MC)) u_banked_core_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_core_id(req_core_id), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .alias_err(alias_err),
    .core_irq(core_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] adr(input int win, input int off);
    return AW'(win * 32 + off);
  endfunction

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [IDW-1:0] id, input logic [1:0] sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    req_core_id = id; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    errSeen = alias_err;
  endtask

  task automatic checkLoads(input string req);
    for (int c = 0; c < NC; c++) begin
      access(1'b0, adr(c + 1, 0), 0, '0, 2'd2);
      chk(req, rd, expLoad[c]);
    end
  endtask

  initial begin
    #(CLK_HALF * 2 * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state of every register of every core
    chk("R10 irq", 32'(core_irq), 0);
    chk("R10 err", 32'(alias_err), 0);
    for (int c = 0; c < NC; c++)
      for (int o = 0; o < 4; o++) begin
        access(1'b0, adr(c + 1, o * 4), 0, '0, 2'd2);
        chk("R10 reg", rd, 0);
      end

    // R2: load written per fixed window, read back per fixed window
    for (int c = 0; c < NC; c++) begin
      expLoad[c] = 32'h1000 + 32'(c) * 32'h111;
      access(1'b1, adr(c + 1, 0), expLoad[c], '0, 2'd2);
    end
    for (int c = 0; c < NC; c++) begin
      access(1'b0, adr(c + 1, 0), 0, '0, 2'd2);
      chk("R2 load", rd, expLoad[c]);
      access(1'b0, adr(c + 1, 4), 0, '0, 2'd2);
      chk("R1 load copies to count", rd, expLoad[c]);
    end

    // R3: alias reads by every valid core ID
    for (int c = 0; c < NC; c++) begin
      access(1'b0, adr(0, 0), 0, IDW'(c), 2'd2);
      chk("R3 alias read", rd, expLoad[c]);
      chk("R3 no err", 32'(errSeen), 0);
    end
    // R3: alias count writes land on the requesting core
    for (int c = 0; c < NC; c++)
      access(1'b1, adr(0, 4), 32'h50 + 32'(c), IDW'(c), 2'd2);
    for (int c = 0; c < NC; c++) begin
      access(1'b0, adr(c + 1, 4), 0, '0, 2'd2);
      chk("R3 alias write", rd, 32'h50 + 32'(c));
    end

    // R4: alias access from an unknown core
    access(1'b1, adr(0, 0), 32'hDEAD_BEEF, IDW'(3), 2'd2);
    chk("R4 write err pulse", 32'(errSeen), 1);
    @(negedge clk);
    chk("R4 err single cycle", 32'(alias_err), 0);
    access(1'b0, adr(0, 0), 0, IDW'(3), 2'd2);
    chk("R4 read zero", rd, 0);
    chk("R4 read err pulse", 32'(errSeen), 1);
    checkLoads("R4 write ignored");

    // R5: windows past the last core
    for (int w = NC + 1; w < 8; w++) begin
      access(1'b1, adr(w, 0), 32'hCAFE_0000 + 32'(w), '0, 2'd2);
      chk("R5 write no err", 32'(errSeen), 0);
      access(1'b0, adr(w, 0), 0, '0, 2'd2);
      chk("R5 read zero", rd, 0);
    end
    checkLoads("R5 write ignored");

    // R1: unused offsets read zero
    for (int o = 4; o < 8; o++) begin
      access(1'b1, adr(1, o * 4), 32'hFFFF_FFFF, '0, 2'd2);
      access(1'b0, adr(1, o * 4), 0, '0, 2'd2);
      chk("R1 unused offset", rd, 0);
    end

    // R6: partial and misaligned accesses
    for (int s = 0; s < 2; s++) begin
      access(1'b1, adr(2, 0), 32'h0BAD_0BAD, '0, 2'(s));
      access(1'b0, adr(2, 0), 0, '0, 2'(s));
      chk("R6 partial read zero", rd, 0);
    end
    access(1'b1, adr(3, 1), 32'h0BAD_0BAD, '0, 2'd2);
    access(1'b0, adr(3, 1), 0, '0, 2'd2);
    chk("R6 misaligned read zero", rd, 0);
    checkLoads("R6 write ignored");

    // R7: read data holds while no new read comes
    access(1'b0, adr(1, 0), 0, '0, 2'd2);
    access(1'b1, adr(2, 4), 32'h77, '0, 2'd2);
    @(negedge clk);
    chk("R7 hold", rsp_rdata, expLoad[0]);

    // R8: core 1 expiry, exact cycle and its own line only
    access(1'b1, adr(2, 0), 32'd4, '0, 2'd2);
    access(1'b1, adr(2, 8), 32'h5, '0, 2'd2);
    n = 0;
    while (core_irq == '0 && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk("R8 expiry cycles", 32'(n), 4);
    chk("R8 irq line", 32'(core_irq), 32'b010);
    access(1'b0, adr(0, 12), 0, IDW'(1), 2'd2);
    chk("R8 status", rd, 1);
    access(1'b0, adr(2, 8), 0, '0, 2'd2);
    chk("R8 control readback", rd, 32'h5);

    // R9: write 0 keeps status, write 1 clears it
    access(1'b1, adr(0, 12), 32'h0, IDW'(1), 2'd2);
    @(negedge clk);
    chk("R9 write zero keeps", 32'(core_irq), 32'b010);
    access(1'b1, adr(0, 12), 32'h1, IDW'(1), 2'd2);
    chk("R9 clear", 32'(core_irq), 0);

    // R10: reset after activity
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < NC; c++) expLoad[c] = 0;
    checkLoads("R10 reset clears");
    access(1'b0, adr(2, 8), 0, '0, 2'd2);
    chk("R10 control", rd, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule